// File: doc/BRIEF.md
# Single-Wire Bus Session Controller

This block keeps the power and session state of a slave device that hangs on a single-wire, open-drain host line carrying UART-style frames. While the device sleeps, it watches the line. It discards low pulses too short to be a real host break. When a genuine break arrives, it wakes and answers with a break of its own by pulling the line low. Once awake, it falls back to sleep after a long stretch with no line activity, or at once when the frame decoder reports the sleep opcode. A soft-reset instruction restarts the session and is acknowledged with a fresh break.

The frame decoder beside this block reports decoded instructions as one-cycle strobes. After the last bit of a challenge word, and after the last bit of the second data frame of a one-time-programmable write, the controller reports a busy window of fixed length. Any instruction that lands inside a busy window is dropped and flagged on an error strobe. Every window is a cycle count derived from the clock frequency, the bit rate and time parameters. Byte framing, the hash engine and the storage array sit outside this block.

Top module: `swb_session_ctrl`

## Requirements
- R1: After reset the session state output reads 0 (SLEEP), and `pull_low`, `busy`, `awake` and `cmd_err` are all 0. The state codes are 0 SLEEP, 1 WAKE_ECHO, 2 IDLE, 3 BUSY_HASH, 4 BUSY_OTP and 5 RESET.
- R2: In SLEEP, a low pulse on `line_in` shorter than `DGL_US` microseconds leaves the state at 0 and never asserts `pull_low`. A pulse of at least that length wakes the device.
- R3: After an accepted host break, `pull_low` rises between 35 and 100 µs after the host's falling edge (60 µs by default). It stays high for `BRK_BITS` bit times, and the state then reads 2 (IDLE).
- R4: In any state other than SLEEP, `SLEEP_MS` milliseconds with no accepted line edge returns the state to 0. Every accepted edge, rising or falling, restarts that interval.
- R5: An `op_sleep` strobe in IDLE puts the state at 0 and drops `awake` on the next clock edge.
- R6: An `op_reset` strobe in IDLE moves the state to 5. After `RST_US` microseconds, `pull_low` is held for `BRK_BITS` bit times, and the state then reads 2.
- R7: An `op_chal` strobe in IDLE moves the state to 3. `busy` then stays high for exactly `HASH_BITS` bit times, which is at most 30 bit times, and the state returns to 2.
- R8: An `op_otp` strobe in IDLE moves the state to 4. `busy` then stays high for exactly `OTP_US` microseconds, and the state returns to 2.
- R9: Any strobe that arrives while `busy` is high leaves the state and the remaining length of the window unchanged. It raises `cmd_err` for exactly one cycle, starting at the next clock edge.
- R10: When several strobes arrive together in IDLE, `op_reset` wins over `op_sleep`, which wins over `op_otp`, which wins over `op_chal`.
- R11: Strobes that arrive in SLEEP leave the state at 0 and do not raise `cmd_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Sampled level of the bus line (asynchronous) |
| op_sleep | input | 1 | Strobe: sleep opcode decoded |
| op_reset | input | 1 | Strobe: last bit of soft-reset instruction |
| op_chal | input | 1 | Strobe: last bit of challenge word |
| op_otp | input | 1 | Strobe: last bit of second write data frame |
| op_cmd | input | 1 | Strobe: any other decoded instruction |
| pull_low | output | 1 | Drives the open-drain line low when 1 |
| busy | output | 1 | Hash or write window active |
| awake | output | 1 | Device is out of SLEEP (internal supply on) |
| state_o | output | 3 | Session state code (see R1) |
| cmd_err | output | 1 | One-cycle flag: instruction dropped while busy |

## Verification
A wrong state shows at the ports almost at once, because `state_o`, `busy` and `awake` are decoded straight from the state register. A mistaken transition is therefore visible on the clock edge after the strobe or line event that caused it. Timer faults take longer to appear. A wrong busy, echo or reset window shows up only when `busy` or `pull_low` falls off its exact cycle count. An inactivity-counter fault shows up only when `awake` drops too early, or fails to drop about one timeout after the last accepted edge. A filter fault shows up as a wake from a short pulse, or as no wake from a real break.

// File: rtl/swb_pkg.sv
// Shared types for the single-wire bus session controller.
// Assumes nothing beyond a 3-bit state code seen by neighbouring logic.
package swb_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_WAKE  = 3'd1,
        ST_IDLE  = 3'd2,
        ST_HASH  = 3'd3,
        ST_OTP   = 3'd4,
        ST_RST   = 3'd5
    } swb_state_e;

    function automatic int unsigned swb_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/swb_glitch_filter.sv
// Line conditioner: two-flop synchroniser followed by a persistence filter.
// A new level is accepted only once the synchronised line has differed from
// the filtered level on DG_CYC consecutive clock edges.
// Assumes the line idles high (pulled up) and DG_CYC >= 2.
module swb_glitch_filter #(
    parameter int unsigned DG_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic level,
    output logic edge_any,
    output logic fall
);
    localparam int unsigned CW = $clog2(DG_CYC + 1);

    logic          sync1, sync2, level_d;
    logic [CW-1:0] run_cnt;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= line_raw;
            sync2 <= sync1;
        end
    end

    // Accept a level change only after it persists for the full window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= 1'b1;
            run_cnt <= '0;
        end else if (sync2 != level) begin
            if (run_cnt == CW'(DG_CYC - 1)) begin
                level   <= sync2;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + CW'(1);
            end
        end else begin
            run_cnt <= '0;
        end
    end

    // Delayed copy of the filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b1;
        else        level_d <= level;
    end

    assign edge_any = level_d ^ level;
    assign fall     = level_d & ~level;

endmodule

// File: rtl/swb_idle_timer.sv
// Inactivity counter: counts clock cycles since the last clear and flags
// expiry once LIMIT cycles have passed. It saturates at the limit.
// Assumes LIMIT >= 2.
module swb_idle_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count quiet cycles and hold once the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)           cnt <= '0;
        else if (cnt != CW'(LIMIT - 1)) cnt <= cnt + CW'(1);
    end

    assign expired = (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/swb_session_ctrl.sv
// Session controller for a slave on a single-wire open-drain bus.
// It wakes on a filtered host break and echoes a break, auto-sleeps on
// inactivity, obeys the sleep and soft-reset strobes, and times the busy
// windows that follow a challenge word or a storage write.
// Assumes CLK_HZ is a whole multiple of 1 MHz and that the strobes come from
// a frame decoder, one cycle each.
module swb_session_ctrl #(
    parameter int unsigned CLK_HZ    = 4_000_000,
    parameter int unsigned BIT_HZ    = 20_000,
    parameter int unsigned DGL_US    = 10,
    parameter int unsigned ECHO_US   = 60,
    parameter int unsigned BRK_BITS  = 2,
    parameter int unsigned HASH_BITS = 20,
    parameter int unsigned OTP_US    = 1800,
    parameter int unsigned RST_US    = 30,
    parameter int unsigned SLEEP_MS  = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    input  logic       op_sleep,
    input  logic       op_reset,
    input  logic       op_chal,
    input  logic       op_otp,
    input  logic       op_cmd,
    output logic       pull_low,
    output logic       busy,
    output logic       awake,
    output logic [2:0] state_o,
    output logic       cmd_err
);
    import swb_pkg::*;

    localparam int unsigned CYC_US    = CLK_HZ / 1_000_000;
    localparam int unsigned BIT_CYC   = CLK_HZ / BIT_HZ;
    localparam int unsigned DG_CYC    = DGL_US * CYC_US;
    localparam int unsigned ECHO_WAIT = ECHO_US * CYC_US - DG_CYC - 3;
    localparam int unsigned BRK_CYC   = BRK_BITS * BIT_CYC;
    localparam int unsigned HASH_CYC  = HASH_BITS * BIT_CYC;
    localparam int unsigned OTP_CYC   = OTP_US * CYC_US;
    localparam int unsigned RST_CYC   = RST_US * CYC_US;
    localparam int unsigned SLEEP_CYC = SLEEP_MS * 1000 * CYC_US;
    localparam int unsigned TMAX      = swb_max(swb_max(ECHO_WAIT, BRK_CYC),
                                        swb_max(swb_max(HASH_CYC, OTP_CYC), RST_CYC));
    localparam int unsigned TW        = $clog2(TMAX + 1);

    swb_state_e    state;
    logic [TW-1:0] tmr;
    logic          drive;
    logic          lvl, edge_any, fall, idle_exp;
    logic          any_op;

    swb_glitch_filter #(.DG_CYC(DG_CYC)) i_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (line_in),
        .level    (lvl),
        .edge_any (edge_any),
        .fall     (fall)
    );

    swb_idle_timer #(.LIMIT(SLEEP_CYC)) i_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (edge_any || (state == ST_SLEEP)),
        .expired (idle_exp)
    );

    assign any_op = op_sleep | op_reset | op_chal | op_otp | op_cmd;

    // Session state machine with one shared window timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_SLEEP;
            tmr     <= '0;
            drive   <= 1'b0;
            cmd_err <= 1'b0;
        end else begin
            cmd_err <= 1'b0;
            if (state != ST_SLEEP && idle_exp) begin
                state <= ST_SLEEP;
                drive <= 1'b0;
            end else begin
                case (state)
                    ST_SLEEP: if (fall) begin
                        state <= ST_WAKE;
                        tmr   <= TW'(ECHO_WAIT - 1);
                        drive <= 1'b0;
                    end
                    ST_WAKE: begin
                        if (tmr != '0) begin
                            tmr <= tmr - TW'(1);
                        end else if (!drive) begin
                            drive <= 1'b1;
                            tmr   <= TW'(BRK_CYC - 1);
                        end else begin
                            drive <= 1'b0;
                            state <= ST_IDLE;
                        end
                    end
                    ST_IDLE: begin
                        if (op_reset) begin
                            state <= ST_RST;
                            tmr   <= TW'(RST_CYC - 1);
                        end else if (op_sleep) begin
                            state <= ST_SLEEP;
                        end else if (op_otp) begin
                            state <= ST_OTP;
                            tmr   <= TW'(OTP_CYC - 1);
                        end else if (op_chal) begin
                            state <= ST_HASH;
                            tmr   <= TW'(HASH_CYC - 1);
                        end
                    end
                    ST_HASH, ST_OTP: begin
                        cmd_err <= any_op;
                        if (tmr == '0) state <= ST_IDLE;
                        else           tmr   <= tmr - TW'(1);
                    end
                    ST_RST: begin
                        if (tmr == '0) begin
                            state <= ST_WAKE;
                            drive <= 1'b1;
                            tmr   <= TW'(BRK_CYC - 1);
                        end else begin
                            tmr <= tmr - TW'(1);
                        end
                    end
                    default: state <= ST_SLEEP;
                endcase
            end
        end
    end

    assign pull_low = (state == ST_WAKE) && drive;
    assign busy     = (state == ST_HASH) || (state == ST_OTP);
    assign awake    = (state != ST_SLEEP);
    assign state_o  = state;

endmodule

// File: rtl/swb_session_chk.sv
// Property checker for the session controller, bound to every instance.
// It observes only the top-level ports.
module swb_session_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_sleep,
    input logic       op_reset,
    input logic       op_chal,
    input logic       op_otp,
    input logic       op_cmd,
    input logic       pull_low,
    input logic       busy,
    input logic [2:0] state_o,
    input logic       cmd_err
);
    import swb_pkg::*;

    logic any_op;
    assign any_op = op_sleep | op_reset | op_chal | op_otp | op_cmd;

    a_r9_err_on_busy_op: assert property (@(posedge clk) disable iff (!rst_n)
        busy && any_op |=> cmd_err);

    a_r11_no_err_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !cmd_err);

    a_r9_busy_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_HASH) && op_reset |=>
        (state_o == ST_HASH || state_o == ST_IDLE || state_o == ST_SLEEP));

    a_r5_sleep_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE) && op_sleep && !op_reset |=> state_o == ST_SLEEP);

    a_r6_reset_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE) && op_reset |=>
        (state_o == ST_RST || state_o == ST_SLEEP));

    a_r3_break_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_low) |-> ($past(state_o) == ST_WAKE || $past(state_o) == ST_RST));

    a_r11_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == ST_SLEEP |=> (state_o == ST_SLEEP || state_o == ST_WAKE));

endmodule

bind swb_session_ctrl swb_session_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_sleep (op_sleep),
    .op_reset (op_reset),
    .op_chal  (op_chal),
    .op_otp   (op_otp),
    .op_cmd   (op_cmd),
    .pull_low (pull_low),
    .busy     (busy),
    .state_o  (state_o),
    .cmd_err  (cmd_err)
);

// File: tb/test_swb_session_ctrl.sv
`timescale 1ns/1ps
// Bench for the session controller: seeded random break widths and strobe
// mixes plus directed corner cases, checked against expected values
// derived from the requirements.
module test_swb_session_ctrl;

    localparam int DG   = 10;     // DGL_US at one cycle per microsecond
    localparam int BIT  = 50;     // 1 MHz / 20 kbps
    localparam int BRK  = 2 * BIT;
    localparam int HASH = 20 * BIT;
    localparam int OTP  = 1800;
    localparam int RST  = 30;
    localparam int SLP  = 5000;   // 5 ms

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_low = 1'b0;
    logic       op_sleep = 1'b0, op_reset = 1'b0, op_chal = 1'b0, op_otp = 1'b0, op_cmd = 1'b0;
    logic       pull_low, busy, awake, cmd_err;
    logic [2:0] state_o;
    logic       line_in;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    assign line_in = ~(host_low | pull_low);

    always #2 clk = ~clk;

    swb_session_ctrl #(
        .CLK_HZ(1_000_000), .BIT_HZ(20_000), .DGL_US(10), .ECHO_US(60),
        .BRK_BITS(2), .HASH_BITS(20), .OTP_US(1800), .RST_US(30), .SLEEP_MS(5)
    ) i_swb_session_ctrl (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .op_sleep(op_sleep), .op_reset(op_reset), .op_chal(op_chal),
        .op_otp(op_otp), .op_cmd(op_cmd),
        .pull_low(pull_low), .busy(busy), .awake(awake),
        .state_o(state_o), .cmd_err(cmd_err)
    );

    function automatic int exp_wake(input int w);
        return (w >= DG) ? 2 : 0;
    endfunction

    function automatic int exp_prio(input bit r, input bit s, input bit o, input bit c);
        if (r) return 5;
        if (s) return 0;
        if (o) return 4;
        if (c) return 3;
        return 2;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_pulse(input int w);
        @(negedge clk); host_low = 1'b1;
        repeat (w) @(negedge clk);
        host_low = 1'b0;
    endtask

    task automatic ping();
        host_pulse(25);
        tick(40);
    endtask

    task automatic do_op(input bit s, input bit r, input bit o, input bit c, input bit m);
        @(negedge clk);
        op_sleep = s; op_reset = r; op_otp = o; op_chal = c; op_cmd = m;
        @(negedge clk);
        op_sleep = 0; op_reset = 0; op_otp = 0; op_chal = 0; op_cmd = 0;
    endtask

    // Host break from SLEEP, then measure echo delay and echo length (R3).
    task automatic wake_and_check();
        int n = 0;
        int m = 0;
        @(negedge clk); host_low = 1'b1;
        while (!pull_low && n < 400) begin
            @(negedge clk); n++;
            if (n == 25) host_low = 1'b0;
        end
        chk_rng("R3 echo delay us", n, 35, 100);
        while (pull_low && m < 1000) begin
            @(negedge clk); m++;
        end
        chk("R3 echo length cycles", m, BRK);
        chk("R3 state after echo", state_o, 2);
    endtask

    // Count negedges with busy high, starting at the current one.
    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++; @(negedge clk);
        end
    endtask

    initial begin
        int n;
        void'($urandom(32'h5EED_0042));
        tick(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 state", state_o, 0);
        chk("R1 pull_low", pull_low, 0);
        chk("R1 busy", busy, 0);
        chk("R1 awake", awake, 0);
        chk("R1 cmd_err", cmd_err, 0);

        // R2: pulse one cycle short of the filter window is rejected
        host_pulse(DG - 1);
        tick(150);
        chk("R2 short pulse state", state_o, 0);
        chk("R2 short pulse no drive", pull_low, 0);

        // R11: strobes in SLEEP are ignored without error
        do_op(0, 0, 0, 1, 1);
        chk("R11 state in sleep", state_o, 0);
        chk("R11 no cmd_err", cmd_err, 0);

        // R3: genuine break wakes and echoes
        wake_and_check();

        // R5: sleep opcode
        do_op(1, 0, 0, 0, 0);
        chk("R5 state", state_o, 0);
        chk("R5 awake", awake, 0);

        // R2: random break widths around the filter window, plus the exact edge
        for (int i = 0; i < 9; i++) begin
            int w = (i == 8) ? DG : int'($urandom_range(1, 30));
            host_pulse(w);
            tick(250);
            chk($sformatf("R2 pulse width %0d", w), state_o, exp_wake(w));
            if (state_o == 3'd2) do_op(1, 0, 0, 0, 0);
        end

        wake_and_check();

        // R7: challenge busy window
        ping();
        do_op(0, 0, 0, 1, 0);
        chk("R7 state", state_o, 3);
        count_busy(n);
        chk("R7 busy cycles", n, HASH);
        chk_rng("R7 within 30 bit times", n, 1, 30 * BIT);
        chk("R7 back to idle", state_o, 2);

        // R8: write busy window
        ping();
        do_op(0, 0, 1, 0, 0);
        chk("R8 state", state_o, 4);
        count_busy(n);
        chk("R8 busy cycles", n, OTP);
        chk("R8 back to idle", state_o, 2);

        // R9: instruction inside the challenge window
        ping();
        do_op(0, 0, 0, 1, 0);
        tick(10);
        do_op(0, 1, 0, 0, 0);
        chk("R9 cmd_err raised", cmd_err, 1);
        chk("R9 state unchanged", state_o, 3);
        count_busy(n);
        chk("R9 window length unchanged", n, HASH - 12);
        chk("R9 cmd_err one cycle", cmd_err, 0);

        // R9: generic instruction inside the write window
        ping();
        do_op(0, 0, 1, 0, 0);
        do_op(0, 0, 0, 0, 1);
        chk("R9 cmd_err in write window", cmd_err, 1);
        chk("R9 state in write window", state_o, 4);
        count_busy(n);
        chk("R9 write window length", n, OTP - 2);

        // R6: soft reset then echo break
        ping();
        do_op(0, 1, 0, 0, 0);
        chk("R6 state", state_o, 5);
        n = 0;
        while (!pull_low && n < 500) begin
            n++; @(negedge clk);
        end
        chk("R6 reset delay cycles", n, RST);
        n = 0;
        while (pull_low && n < 1000) begin
            n++; @(negedge clk);
        end
        chk("R6 break length", n, BRK);
        chk("R6 state after break", state_o, 2);

        // R10: all strobes at once
        ping();
        do_op(1, 1, 1, 1, 0);
        chk("R10 reset wins", state_o, 5);
        tick(RST + BRK + 5);

        // R10: random strobe mixes in IDLE
        for (int i = 0; i < 8; i++) begin
            bit r = 1'($urandom_range(0, 1));
            bit s = 1'($urandom_range(0, 1));
            bit o = 1'($urandom_range(0, 1));
            bit c = 1'($urandom_range(0, 1));
            int e = exp_prio(r, s, o, c);
            ping();
            do_op(s, r, o, c, 0);
            chk($sformatf("R10 mix r%0d s%0d o%0d c%0d", r, s, o, c), state_o, e);
            if (e == 0) begin
                wake_and_check();
            end else begin
                n = 0;
                while (state_o != 3'd2 && n < 4000) begin
                    n++; @(negedge clk);
                end
            end
        end

        // R4: each accepted edge restarts the inactivity interval
        ping();
        tick(SLP - 1000);
        host_pulse(25);
        tick(SLP - 1000);
        chk("R4 still awake after restart", awake, 1);

        // R4: timeout measured from the last host release
        host_pulse(25);
        n = 0;
        while (awake && n < 8000) begin
            n++; @(negedge clk);
        end
        chk_rng("R4 timeout cycles", n, SLP, SLP + DG + 6);
        chk("R4 state after timeout", state_o, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual 200000 cycles expected completion earlier");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule